// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Unit

This block gathers the event sources of an I2C controller into one interrupt line. Ten sources arrive as single-cycle pulses from the bus engine and are held in a sticky raw-status vector. Two sources, receive-buffer-at-threshold and transmit-buffer-low, are not held: they follow level inputs driven by the buffer logic. A software-writable enable vector qualifies the raw vector into a masked view, and any qualified bit raises the registered interrupt output.

Software clears held bits by reading registers, not by writing them. Each held source has its own clear address, and one further address clears every held bit at once. A 13-bit abort-cause register collects the reasons for a transfer abort. It is wiped whenever the abort event is cleared, so software must read the cause before it reads the abort clear address. If an event arrives in the same cycle as the read that clears it, the event wins and nothing is lost.

Access is through a plain address / read-strobe / write-strobe register port, with read data registered one cycle after the strobe.

Top module: `i2c_irq_unit`

## Requirements
- R1: Held sources set their raw-status bit on an event pulse and keep it. The bit positions are: receive underrun 0, receive overrun 1, transmit overrun 3, read request 5, abort 6, receive done 7, activity 8, stop seen 9, start seen 10, general call 11. The raw status reads at offset 0x34, bits 11:0.
- R2: Raw bit 2 mirrors the `rxfull_lvl` input and raw bit 4 mirrors the `txempty_lvl` input in the same cycle. Event pulses on bits 2 and 4 have no effect.
- R3: The enable vector is 12 bits wide, read and written at 0x30. Masked status at 0x2C equals raw AND enable. Writes to any other offset change no state.
- R4: `irq_o` is a register that takes the OR of the masked-status bits one clock after they are present.
- R5: A read of a per-source clear address clears only that source's held bit and returns the bit's prior value in bit 0. The addresses step by 4 from 0x44 in this order: underrun 0x44, overrun 0x48, transmit overrun 0x4C, read request 0x50, abort 0x54, receive done 0x58, activity 0x5C, stop 0x60, start 0x64, general call 0x68.
- R6: An event pulse in the same cycle as a clear of that source leaves the bit set.
- R7: A read of 0x40 clears every held bit and the abort-cause register. It returns, in bit 0, the OR of the held bits before the clear.
- R8: The abort-cause register at 0x80 ORs in the `cause_set` pulses and keeps them. Bits 6 and 8 always read 0.
- R9: A read of 0x54 zeroes the abort-cause register; a `cause_set` pulse in that same cycle survives. Reads of other per-source clear addresses leave the abort-cause register unchanged.
- R10: Reset, synchronous and active high, gives raw status 0, abort cause 0, `irq_o` 0, read data 0 and enable 0xFFF.
- R11: Read data appears one cycle after the read strobe. Unmapped or misaligned offsets read 0, and read data is 0 after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 12 | Single-cycle event pulses, one per status bit |
| rxfull_lvl | input | 1 | Receive buffer at threshold (level) |
| txempty_lvl | input | 1 | Transmit buffer low (level) |
| cause_set | input | 13 | Abort reason pulses |
| bus_addr | input | 8 | Register byte offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two functions can land in the same clock edge: an event pulse raising a held bit, and the clear read that drops it. The same applies to an abort-reason pulse and the abort clear that wipes the cause register. The bench provokes each collision by driving the pulse in the very cycle it issues the clear read. It judges the outcome from the returned clear data (the prior value) and from a following read of raw status or of the cause register, which must still show the new event. It also checks that a neighbouring clear read leaves the cause register intact.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int NSRC    = 12;
    localparam int CAUSE_W = 13;
    localparam int NCLR    = 10;

    // status bit positions
    localparam int SRC_RX_UNDER  = 0;
    localparam int SRC_RX_OVER   = 1;
    localparam int SRC_RX_FULL   = 2;
    localparam int SRC_TX_OVER   = 3;
    localparam int SRC_TX_EMPTY  = 4;
    localparam int SRC_RD_REQ    = 5;
    localparam int SRC_ABORT     = 6;
    localparam int SRC_RX_DONE   = 7;
    localparam int SRC_ACTIVITY  = 8;
    localparam int SRC_STOP      = 9;
    localparam int SRC_START     = 10;
    localparam int SRC_GCALL     = 11;

    localparam logic [NSRC-1:0] LEVEL_SRC =
        (NSRC'(1) << SRC_RX_FULL) | (NSRC'(1) << SRC_TX_EMPTY);
    localparam logic [NSRC-1:0] HELD_SRC = ~LEVEL_SRC;

    // cause bits 6 and 8 are not implemented
    localparam logic [CAUSE_W-1:0] CAUSE_LIVE =
        ~((CAUSE_W'(1) << 6) | (CAUSE_W'(1) << 8));

    typedef logic [7:0] reg_ofs_t;

    localparam reg_ofs_t OFS_MASKED    = 8'h2C;
    localparam reg_ofs_t OFS_ENABLE    = 8'h30;
    localparam reg_ofs_t OFS_RAW       = 8'h34;
    localparam reg_ofs_t OFS_CLR_ALL   = 8'h40;
    localparam reg_ofs_t OFS_CLR_FIRST = 8'h44;
    localparam reg_ofs_t OFS_CAUSE     = 8'h80;
    localparam reg_ofs_t OFS_CLR_LAST  = OFS_CLR_FIRST + reg_ofs_t'(4 * (NCLR - 1));

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_MASKED,
        RSEL_ENABLE,
        RSEL_RAW,
        RSEL_CLR_ALL,
        RSEL_CLR_ONE,
        RSEL_CAUSE
    } rsel_e;

    typedef struct packed {
        logic [NSRC-1:0] one;
        logic            all;
    } clr_req_t;

    // slot index of a clear address to the status bit it serves;
    // the two level sources are skipped in the address sequence
    function automatic int slot_to_bit(input int slot);
        if (slot < 2)       return slot;
        else if (slot == 2) return SRC_TX_OVER;
        else                return slot + 2;
    endfunction

    function automatic logic [NSRC-1:0] clear_onehot(input reg_ofs_t a);
        logic [NSRC-1:0] v;
        int              slot;
        v = '0;
        if (a >= OFS_CLR_FIRST && a <= OFS_CLR_LAST && a[1:0] == 2'b00) begin
            slot = int'((a - OFS_CLR_FIRST) >> 2);
            v[slot_to_bit(slot)] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/i2c_irq_regdec.sv
module i2c_irq_regdec
    import i2c_irq_pkg::*;
(
    input  reg_ofs_t  addr,
    input  logic      rd,
    input  logic      wr,
    output clr_req_t  clr,
    output logic      enable_we,
    output rsel_e     rsel
);

    logic [NSRC-1:0] one_hit;

    assign one_hit   = clear_onehot(addr);
    assign enable_we = wr && (addr == OFS_ENABLE);

    always_comb begin
        clr.one = rd ? one_hit : '0;
        clr.all = rd && (addr == OFS_CLR_ALL);
    end

    always_comb begin
        rsel = RSEL_NONE;
        if (rd) begin
            if (|one_hit)                  rsel = RSEL_CLR_ONE;
            else if (addr == OFS_MASKED)   rsel = RSEL_MASKED;
            else if (addr == OFS_ENABLE)   rsel = RSEL_ENABLE;
            else if (addr == OFS_RAW)      rsel = RSEL_RAW;
            else if (addr == OFS_CLR_ALL)  rsel = RSEL_CLR_ALL;
            else if (addr == OFS_CAUSE)    rsel = RSEL_CAUSE;
        end
    end

endmodule

// File: rtl/i2c_irq_srcbank.sv
module i2c_irq_srcbank
    import i2c_irq_pkg::*;
#(
    parameter int              W      = NSRC,
    parameter logic [W-1:0]    HELD   = HELD_SRC
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] clr,
    output logic [W-1:0] held_q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                held_q[i] <= 1'b0;
            else
                held_q[i] <= HELD[i] ? ((held_q[i] & ~clr[i]) | ev[i]) : 1'b0;
        end

        if (HELD[i]) begin : g_chk
            // event in the same cycle as its clear must survive
            assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
                ev[i] |=> held_q[i]);
            assert_clear_drops_R5: assert property (@(posedge clk) disable iff (rst)
                (clr[i] && !ev[i]) |=> !held_q[i]);
            assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
                (held_q[i] && !clr[i]) |=> held_q[i]);
        end
    end

endmodule

// File: rtl/i2c_irq_cause.sv
module i2c_irq_cause
    import i2c_irq_pkg::*;
#(
    parameter int               W    = CAUSE_W,
    parameter logic [W-1:0]     LIVE = CAUSE_LIVE
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         wipe,
    output logic [W-1:0] cause_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cause_q <= '0;
        else
            cause_q <= LIVE & ((wipe ? '0 : cause_q) | set);
    end

    assert_cause_wiped_R9: assert property (@(posedge clk) disable iff (rst)
        (wipe && set == '0) |=> cause_q == '0);
    assert_cause_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (!wipe) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    ev_pulse,
    input  logic               rxfull_lvl,
    input  logic               txempty_lvl,
    input  logic [CAUSE_W-1:0] cause_set,
    input  logic [7:0]         bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);

    clr_req_t           clr;
    logic               enable_we;
    rsel_e              rsel;
    logic [NSRC-1:0]    clr_vec;
    logic [NSRC-1:0]    held;
    logic [NSRC-1:0]    lvl;
    logic [NSRC-1:0]    raw;
    logic [NSRC-1:0]    masked;
    logic [NSRC-1:0]    enable_q;
    logic [CAUSE_W-1:0] cause;
    logic               cause_wipe;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NSRC];

    i2c_irq_regdec u_dec (
        .addr      (bus_addr),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .clr       (clr),
        .enable_we (enable_we),
        .rsel      (rsel)
    );

    assign clr_vec    = clr.all ? '1 : clr.one;
    assign cause_wipe = clr.all | clr.one[SRC_ABORT];

    i2c_irq_srcbank u_bank (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev_pulse),
        .clr    (clr_vec),
        .held_q (held)
    );

    i2c_irq_cause u_cause (
        .clk     (clk),
        .rst     (rst),
        .set     (cause_set),
        .wipe    (cause_wipe),
        .cause_q (cause)
    );

    always_comb begin
        lvl               = '0;
        lvl[SRC_RX_FULL]  = rxfull_lvl;
        lvl[SRC_TX_EMPTY] = txempty_lvl;
    end

    assign raw    = held | lvl;
    assign masked = raw & enable_q;

    always_ff @(posedge clk) begin
        if (rst)
            enable_q <= '1;
        else if (enable_we)
            enable_q <= bus_wdata[NSRC-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |masked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            unique case (rsel)
                RSEL_MASKED:  bus_rdata <= DATA_W'(masked);
                RSEL_ENABLE:  bus_rdata <= DATA_W'(enable_q);
                RSEL_RAW:     bus_rdata <= DATA_W'(raw);
                RSEL_CLR_ALL: bus_rdata <= DATA_W'(|held);
                RSEL_CLR_ONE: bus_rdata <= DATA_W'(|(held & clr.one));
                RSEL_CAUSE:   bus_rdata <= DATA_W'(cause);
                default:      bus_rdata <= '0;
            endcase
        end
    end

    assert_irq_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (|masked) |=> irq_o);
    assert_irq_fall_R4: assert property (@(posedge clk) disable iff (rst)
        !(|masked) |=> !irq_o);
    assert_enable_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !enable_we |=> $stable(enable_q));
    assert_clear_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr.one));
    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == '0);

endmodule

// File: tb/i2c_irq_unit_bench.sv
module i2c_irq_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] ev = '0;
    logic        rxf = 1'b0;
    logic        txe = 1'b0;
    logic [12:0] cs = '0;
    logic [7:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    logic rd_seen = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    i2c_irq_unit u_i2c_irq_unit (
        .clk         (clk),
        .rst         (rst),
        .ev_pulse    (ev),
        .rxfull_lvl  (rxf),
        .txempty_lvl (txe),
        .cause_set   (cs),
        .bus_addr    (addr),
        .bus_rd      (rd),
        .bus_wr      (wr),
        .bus_wdata   (wdata),
        .bus_rdata   (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: read data is due one cycle after the strobe
    always @(posedge clk) rd_seen <= rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected read result", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    // driver tasks, all entered and left at a falling edge
    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag,
                            input logic [11:0] ev_in = '0, input logic [12:0] cs_in = '0);
        addr = a; rd = 1'b1; ev = ev_in; cs = cs_in;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd = 1'b0; ev = '0; cs = '0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] ev_in, input logic [12:0] cs_in = '0);
        ev = ev_in; cs = cs_in;
        @(negedge clk);
        ev = '0; cs = '0;
    endtask

    task automatic report;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 32'h1, 32'h0);
        report();
    end

    initial begin
        int clr_bit[10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};
        logic [11:0] remain;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        check("R10 rdata after reset", rdata, 32'h0);
        check("R10 irq after reset", {31'h0, irq}, 32'h0);
        bus_read(8'h34, 32'h000, "R10 raw after reset");
        bus_read(8'h30, 32'hFFF, "R10 enable after reset");
        bus_read(8'h80, 32'h000, "R10 cause after reset");

        // R1 held events
        pulse(12'h001);
        bus_read(8'h34, 32'h001, "R1 underrun held");
        check("R4 irq raised", {31'h0, irq}, 32'h1);
        pulse(12'hA00);
        bus_read(8'h34, 32'hA01, "R1 stop and general call held");

        // R2 level sources
        rxf = 1'b1;
        bus_read(8'h34, 32'hA05, "R2 rx level bit2");
        txe = 1'b1;
        bus_read(8'h34, 32'hA15, "R2 tx level bit4");
        rxf = 1'b0; txe = 1'b0;
        pulse(12'h014);
        bus_read(8'h34, 32'hA01, "R2 pulses on level bits ignored");

        // R3 enable and masked view
        bus_write(8'h30, 32'h200);
        bus_read(8'h2C, 32'h200, "R3 masked status");
        bus_read(8'h30, 32'h200, "R3 enable readback");
        bus_write(8'h34, 32'h0);
        bus_write(8'h2C, 32'hFFF);
        bus_write(8'h80, 32'hFFF);
        bus_read(8'h34, 32'hA01, "R3 writes elsewhere ignored (raw)");
        bus_read(8'h30, 32'h200, "R3 writes elsewhere ignored (enable)");
        bus_write(8'h30, 32'h000);
        @(negedge clk);
        check("R4 irq drops when all disabled", {31'h0, irq}, 32'h0);
        bus_write(8'h30, 32'h004);
        rxf = 1'b1;
        @(negedge clk);
        check("R4 irq from rx level", {31'h0, irq}, 32'h1);
        rxf = 1'b0;
        @(negedge clk);
        check("R2 irq follows rx level down", {31'h0, irq}, 32'h0);
        bus_write(8'h30, 32'hFFF);

        // R5 per-source clears
        bus_read(8'h44, 32'h1, "R5 clear underrun returns prior");
        bus_read(8'h34, 32'hA00, "R5 only underrun cleared");
        bus_read(8'h60, 32'h1, "R5 clear stop");
        bus_read(8'h34, 32'h800, "R5 only stop cleared");
        bus_read(8'h44, 32'h0, "R5 clear of empty bit returns 0");
        bus_read(8'h68, 32'h1, "R5 clear general call");
        bus_read(8'h34, 32'h000, "R5 all cleared");

        pulse(12'hFEB);
        remain = 12'hFEB;
        for (int s = 0; s < 10; s++) begin
            bus_read(8'h44 + 8'(4 * s), 32'h1, $sformatf("R5 clear slot %0d", s));
            remain[clr_bit[s]] = 1'b0;
            bus_read(8'h34, {20'h0, remain}, $sformatf("R5 raw after slot %0d", s));
        end

        // R6 event coincides with its clear
        pulse(12'h080);
        bus_read(8'h58, 32'h1, "R6 clear with event returns prior", 12'h080);
        bus_read(8'h34, 32'h080, "R6 event wins over clear");
        bus_read(8'h44, 32'h0, "R6 clear of empty bit with event", 12'h001);
        bus_read(8'h34, 32'h081, "R6 event set during its clear");
        bus_read(8'h40, 32'h1, "R7 clear-all returns any");
        bus_read(8'h34, 32'h000, "R7 raw empty");

        // R8 and R9 abort cause
        pulse(12'h040, 13'h1FFF);
        bus_read(8'h80, 32'h1EBF, "R8 cause with bits 6 and 8 zero");
        pulse(12'h000, 13'h0000);
        bus_read(8'h80, 32'h1EBF, "R8 cause kept");
        bus_read(8'h54, 32'h1, "R9 abort clear returns prior");
        bus_read(8'h80, 32'h0, "R9 cause wiped by abort clear");
        bus_read(8'h34, 32'h000, "R9 abort bit cleared");
        pulse(12'h040, 13'h0009);
        bus_read(8'h54, 32'h1, "R9 abort clear with new cause", 12'h000, 13'h1000);
        bus_read(8'h80, 32'h1000, "R9 cause pulse survives wipe");
        bus_read(8'h48, 32'h0, "R9 other clear read");
        bus_read(8'h80, 32'h1000, "R9 cause untouched by other clear");

        // R7 clear-all
        pulse(12'hFEB, 13'h0003);
        bus_read(8'h40, 32'h1, "R7 clear-all with bits held");
        bus_read(8'h34, 32'h000, "R7 raw cleared");
        bus_read(8'h80, 32'h000, "R7 cause cleared");
        bus_read(8'h40, 32'h0, "R7 clear-all with nothing held");
        @(negedge clk);
        check("R4 irq low after clear-all", {31'h0, irq}, 32'h0);

        // R11 unmapped and idle reads
        bus_read(8'h08, 32'h0, "R11 unmapped offset");
        bus_read(8'h46, 32'h0, "R11 misaligned offset");
        @(negedge clk);
        check("R11 rdata idle", rdata, 32'h0);

        repeat (2) @(negedge clk);
        check("R11 all reads answered", exp_q.size(), 32'h0);
        report();
    end

endmodule